// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupts

This block is a register-mapped general-purpose I/O controller for up to 32 pins. Software sets each pin's direction and, for outputs, the driven level. It reads back the live level of every pin through the same 32-bit register bus. The bus has a byte address, a write strobe, write data and combinational read data. Reads have no side effects.

Each pin can also raise an interrupt. The trigger is chosen per pin from three bitmaps: an edge/level selector, a polarity bit and a dual-edge selector. Together they give active-high level, active-low level, rising edge, falling edge, or any transition. The dual-edge selector exists only when the `HW_REV` parameter is greater than 2, and software can read that revision from a register.

Pin inputs pass through a two-stage synchroniser before any detection. Detected events latch into a status register. The status is masked by an enable register, and any enabled latched event drives a single interrupt line.

Top module: `pio_irq_ctrl`

## Requirements
- R1: The word index is `addr_i[5:2]`. Index 0 is pin level, 1 is direction, 2 is interrupt enable, 3 is raw status, 4 is enabled pending, 5 is clear (reads 0), 6 is edge select, 7 is polarity, 8 is revision (reads `HW_REV`) and 9 is dual-edge select. Any other index reads 0, and bits at or above `NPINS` read 0.
- R2: A direction bit of 1 makes the pin an input, and 0 makes it an output. Direction resets to all ones. `pin_oe_o` is the inverse of the direction register.
- R3: `pin_o` drives the value last written to index 0 and changes only on such a write. A read of index 0 returns the synchronised input level on input pins and the written value on output pins.
- R4: A change on `pin_i` shows in the index-0 read after exactly two rising clock edges. It can latch a status event on the third edge.
- R5: When edge select is 0, the event is a level. Polarity 1 latches while the pin is high, and polarity 0 latches while the pin is low.
- R6: When edge select is 1 and dual-edge is 0, polarity 1 latches a rising edge and polarity 0 latches a falling edge.
- R7: With `HW_REV` > 2, edge select 1 together with dual-edge 1 latches every transition of the pin.
- R8: With `HW_REV` <= 2, index 9 reads 0 and writes to it are ignored, so such pins behave as single-edge pins.
- R9: Writing 1 to bit n of index 5 clears status bit n, and 0 bits leave status unchanged. An event that falls in the same cycle as its clear stays latched.
- R10: Interrupt enable resets to 0. Pending equals status ANDed with enable. `irq_o` is high when any pending bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 6 | Byte address, word aligned |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| pin_i | input | NPINS | Pin input levels |
| pin_o | output | NPINS | Pin output levels |
| pin_oe_o | output | NPINS | Pin output enables, 1 drives the pin |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A clear write and a new event for the same pin can land on the same clock edge. The status update must then keep the event rather than drop it. The bench provokes this by raising an input on a rising-edge pin and timing the clear strobe so that it is sampled on the third edge after the change, which is the edge where that event latches. In the same write it clears a second pin that is already latched. The status read that follows must show the new event kept, the second pin cleared, and every other bit unchanged.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int BUS_W = 32;

  typedef enum logic [3:0] {
    RI_LEVEL = 4'd0,
    RI_DIR   = 4'd1,
    RI_IEN   = 4'd2,
    RI_IST   = 4'd3,
    RI_IPEND = 4'd4,
    RI_ICLR  = 4'd5,
    RI_EDGE  = 4'd6,
    RI_POL   = 4'd7,
    RI_REV   = 4'd8,
    RI_DUAL  = 4'd9
  } reg_idx_e;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_q    <= '0;
    end else begin
      meta_q <= d_i;
      q_q    <= meta_q;
    end
  end

  assign q_o = q_q;

  // R4
  sync_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni, 2) && $past(rst_ni)) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/pio_evt.sv
module pio_evt #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] edge_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] dual_i,
  output logic [W-1:0] evt_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  for (genvar g = 0; g < W; g++) begin : g_pin
    assign evt_o[g] = !edge_i[g] ? (lvl_i[g] == pol_i[g]) :
                      dual_i[g]  ? (lvl_i[g] ^ prev_q[g]) :
                      pol_i[g]   ? (lvl_i[g] & ~prev_q[g]) :
                                   (~lvl_i[g] & prev_q[g]);
  end

  // R6
  edge_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt_o & edge_i & ~(lvl_i ^ prev_q)) == '0));
endmodule

// File: rtl/pio_irq_ctrl.sv
module pio_irq_ctrl
  import pio_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int HW_REV = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [5:0]       addr_i,
  input  logic             we_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] rdata_o,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] pin_o,
  output logic [NPINS-1:0] pin_oe_o,
  output logic             irq_o
);
  localparam int  W        = NPINS;
  localparam bit  HAS_DUAL = (HW_REV > 2);

  logic [3:0]   widx;
  logic         unused_addr;
  logic [W-1:0] wd;
  logic [W-1:0] val_q, dir_q, ien_q, ist_q, edge_q, pol_q, dual_q;
  logic [W-1:0] sync_lvl, evt, clr_mask, pend, lvl_rd;

  assign widx        = addr_i[5:2];
  assign unused_addr = ^addr_i[1:0];
  assign wd          = wdata_i[W-1:0];

  pio_sync #(.W(W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (sync_lvl)
  );

  pio_evt #(.W(W)) u_evt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (sync_lvl),
    .edge_i(edge_q),
    .pol_i (pol_q),
    .dual_i(dual_q),
    .evt_o (evt)
  );

  assign clr_mask = (we_i && widx == RI_ICLR) ? wd : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q  <= '0;
      dir_q  <= '1;
      ien_q  <= '0;
      edge_q <= '0;
      pol_q  <= '0;
      ist_q  <= '0;
    end else begin
      if (we_i && widx == RI_LEVEL) val_q  <= wd;
      if (we_i && widx == RI_DIR)   dir_q  <= wd;
      if (we_i && widx == RI_IEN)   ien_q  <= wd;
      if (we_i && widx == RI_EDGE)  edge_q <= wd;
      if (we_i && widx == RI_POL)   pol_q  <= wd;
      // set wins over clear in the same cycle
      ist_q <= (ist_q & ~clr_mask) | evt;
    end
  end

  if (HAS_DUAL) begin : g_dual
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      dual_q <= '0;
      else if (we_i && widx == RI_DUAL) dual_q <= wd;
    end
  end else begin : g_no_dual
    assign dual_q = '0;
  end

  assign pend   = ist_q & ien_q;
  assign lvl_rd = (dir_q & sync_lvl) | (~dir_q & val_q);

  always_comb begin
    rdata_o = '0;
    case (widx)
      RI_LEVEL: rdata_o[W-1:0] = lvl_rd;
      RI_DIR:   rdata_o[W-1:0] = dir_q;
      RI_IEN:   rdata_o[W-1:0] = ien_q;
      RI_IST:   rdata_o[W-1:0] = ist_q;
      RI_IPEND: rdata_o[W-1:0] = pend;
      RI_EDGE:  rdata_o[W-1:0] = edge_q;
      RI_POL:   rdata_o[W-1:0] = pol_q;
      RI_REV:   rdata_o        = BUS_W'(HW_REV);
      RI_DUAL:  rdata_o[W-1:0] = dual_q;
      default:  rdata_o        = '0;
    endcase
  end

  assign pin_o    = val_q;
  assign pin_oe_o = ~dir_q;
  assign irq_o    = |pend;

  // R9
  st_clear_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((($past(ist_q) & ~ist_q) & ~$past(clr_mask)) == '0));

  // R9
  evt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt) |=> ((ist_q & $past(evt)) == $past(evt)));

  // R3
  pin_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && widx == RI_LEVEL) |=> $stable(pin_o));

  // R10
  ien_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q != $past(ien_q)) |-> $past(we_i && widx == RI_IEN));
endmodule

// File: tb/pio_irq_ctrl_tb.sv
module pio_irq_ctrl_tb;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [N-1:0] pin = '0;
  logic [31:0] rdata, rdata_old;
  logic [N-1:0] pin_o, pin_oe, pin_o_old, pin_oe_old;
  logic        irq, irq_old;
  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  pio_irq_ctrl #(.NPINS(N), .HW_REV(3)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pin), .pin_o(pin_o), .pin_oe_o(pin_oe), .irq_o(irq));

  pio_irq_ctrl #(.NPINS(N), .HW_REV(2)) u_old (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata_old), .pin_i(pin), .pin_o(pin_o_old), .pin_oe_o(pin_oe_old),
    .irq_o(irq_old));

  localparam logic [5:0] A_LVL = 6'h00, A_DIR = 6'h04, A_IEN = 6'h08, A_IST = 6'h0C,
                         A_PND = 6'h10, A_CLR = 6'h14, A_EDG = 6'h18, A_POL = 6'h1C,
                         A_REV = 6'h20, A_DUA = 6'h24;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d, output logic [31:0] d_old);
    @(negedge clk);
    addr = a;
    #1;
    d = rdata;
    d_old = rdata_old;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  function automatic bit ev(int m, bit a, bit b);
    case (m)
      0: return b;
      1: return !b;
      2: return b && !a;
      3: return !b && a;
      default: return a != b;
    endcase
  endfunction

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d, d_old;
    logic [N-1:0] s0, s1, s2, s0o, s1o, s2o, en;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // reset state
    rd(A_IEN, d, d_old); check("R10 enable reset", d, 32'h0);
    rd(A_DIR, d, d_old); check("R2 dir reset", d, 32'hFF);
    check("R2 oe reset", 32'(pin_oe), 32'h0);
    check("R10 irq reset", 32'(irq), 32'h0);
    rd(A_REV, d, d_old); check("R1 rev new", d, 32'd3); check("R1 rev old", d_old, 32'd2);
    rd(6'h28, d, d_old); check("R1 unmapped", d, 32'h0);
    rd(A_CLR, d, d_old); check("R1 clear reads 0", d, 32'h0);

    // direction and value
    wr(A_DIR, 32'hF0);
    check("R2 oe", 32'(pin_oe), 32'h0F);
    wr(A_LVL, 32'hA5);
    check("R3 pin_o", 32'(pin_o), 32'hA5);
    pin = 8'h30;
    settle();
    rd(A_LVL, d, d_old); check("R3 mixed read", d, 32'h35);
    pin = 8'h50;
    @(negedge clk); #1 check("R4 one edge", rdata, 32'h35);
    @(negedge clk); #1 check("R4 two edges", rdata, 32'h55);
    wr(A_DIR, 32'hFF);
    check("R3 pin_o held", 32'(pin_o), 32'hA5);

    // dual-edge register presence
    wr(A_DUA, 32'hFF);
    rd(A_DUA, d, d_old);
    check("R7 dual reg", d, 32'hFF);
    check("R8 dual reg absent", d_old, 32'h0);

    // trigger-mode sweep
    for (int st = 0; st < 2; st++) begin
      for (int m = 0; m < 5; m++) begin
        int mo;
        string tg;
        mo = (m == 4) ? 2 : m;
        tg = (m < 2) ? "R5" : (m == 4) ? "R7" : "R6";
        wr(A_EDG, (m >= 2) ? 32'hFF : 32'h0);
        wr(A_POL, (m == 0 || m == 2 || m == 4) ? 32'hFF : 32'h0);
        wr(A_DUA, (m == 4) ? 32'hFF : 32'h0);
        pin = st[0] ? 8'hFF : 8'h00;
        for (int p = 0; p < N; p++) begin
          en = N'(1 << p);
          wr(A_IEN, 32'(en));
          settle();
          wr(A_CLR, 32'hFF);
          s0  = ev(m,  st[0], st[0]) ? 8'hFF : 8'h00;
          s0o = ev(mo, st[0], st[0]) ? 8'hFF : 8'h00;
          rd(A_IST, d, d_old);
          check({tg, " steady"}, d, 32'(s0));
          check("R8 steady", d_old, 32'(s0o));
          pin[p] = ~pin[p];
          settle();
          s1  = s0  | (ev(m,  st[0], !st[0]) ? en : '0);
          s1o = s0o | (ev(mo, st[0], !st[0]) ? en : '0);
          rd(A_IST, d, d_old);
          check({tg, " toggle"}, d, 32'(s1));
          check("R8 toggle", d_old, 32'(s1o));
          check("R10 irq", 32'(irq), 32'(|(s1 & en)));
          rd(A_PND, d, d_old);
          check("R10 pending", d, 32'(s1 & en));
          pin[p] = ~pin[p];
          settle();
          s2  = s1  | (ev(m,  !st[0], st[0]) ? en : '0);
          s2o = s1o | (ev(mo, !st[0], st[0]) ? en : '0);
          rd(A_IST, d, d_old);
          check({tg, " return"}, d, 32'(s2));
          check("R8 return", d_old, 32'(s2o));
        end
      end
    end

    // clear masks, rising mode
    wr(A_EDG, 32'hFF); wr(A_POL, 32'hFF); wr(A_DUA, 32'h0);
    pin = 8'h00; settle();
    wr(A_CLR, 32'hFF);
    pin = 8'hFF; settle();
    rd(A_IST, d, d_old); check("R6 all rise", d, 32'hFF);
    wr(A_CLR, 32'h0F);
    rd(A_IST, d, d_old); check("R9 partial clear", d, 32'hF0);
    wr(A_CLR, 32'h00);
    rd(A_IST, d, d_old); check("R9 zero clear", d, 32'hF0);

    // clear in the same cycle as a new event
    pin = 8'hFE; settle();
    @(negedge clk) pin = 8'hFF;
    @(negedge clk);
    @(negedge clk) begin addr = A_CLR; we = 1'b1; wdata = 32'h11; end
    @(negedge clk) we = 1'b0;
    rd(A_IST, d, d_old); check("R9 clear vs event", d, 32'hE1);

    finish_run();
  end
endmodule